// File: doc/BRIEF.md
# Interrupt Status and Clear Register Bank

This block gathers twelve event and condition indications from an I2C bus controller and turns them into a small register bank: a raw status register that latches events, a mask register, a masked status view and a single registered interrupt line. Software reads the masked status to learn what needs service. It then clears each serviced event by reading that event's own clear address. Because each clear acts on one source only, an event that fires between the status read and the clear is not lost. A combined clear address also exists. It clears every latched event at once, at the cost of possibly discarding one that arrives just before the read.

Two of the sources are levels rather than events: transmit-below-threshold and receive-at-threshold. They mirror their input directly and cannot be cleared. The transmit-abort event has a companion abort-reason register. It collects reason bits while the abort is pending and empties together with the abort bit. The activity indication on its own only raises the interrupt line while the controller is enabled.

The register port is a simple single-cycle strobe interface. Read data is combinational in the cycle the read strobe is high, and a read's clearing side effect takes place at the clock edge that ends that cycle.

Top module: `irq_status_bank`

## Requirements
- R1: An event source (bits 2 to 11 of `srcIn`) sets its raw status bit on a one-cycle high pulse, and the bit stays set until it is cleared.
- R2: When a pulse arrives in the same cycle as a clear of that source, the raw bit remains set after the edge, and this holds for both the per-source clear and the combined clear.
- R3: A read of the per-source clear address 8+i (i in 2..11) clears raw bit i only; all other raw bits keep their value.
- R4: A read of the combined clear address 4 clears every event bit and returns the raw status as it was before the clear.
- R5: Bit 0 (transmit-below-threshold) and bit 1 (receive-at-threshold) of the raw status follow `srcIn[0]` and `srcIn[1]` directly. Their clear addresses 8 and 9 return 0 and change nothing, and the combined clear does not affect them.
- R6: The masked status (address 1) equals the raw status (address 0) ANDed with the mask register (address 2).
- R7: `irqOut` is the OR of the masked status bits, registered by one clock. A mask of 0 holds `irqOut` low.
- R8: With `ctrlEnable` low, masked activity (bit 5) alone does not raise `irqOut`, but any other masked bit does. With `ctrlEnable` high, masked activity alone raises it.
- R9: On each transmit-abort pulse (bit 2), `abortReasonIn` is ORed into the abort-reason register (address 3). Reason values without a pulse are ignored, and reading address 3 has no side effect.
- R10: A read of the transmit-abort clear (address 10) or of the combined clear empties the abort-reason register. A clear of any other source leaves it unchanged. If an abort pulse coincides with the clear, the register holds exactly the new reason.
- R11: A read of clear address 8+i returns raw bit i before the clear in data bit 0. Writes to any address other than 2 change nothing, and reads of unused addresses return 0.
- R12: After reset the raw event bits, the mask, the abort-reason register and `irqOut` are all 0. The mask keeps the low 12 bits of a write to address 2 and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regRdEn | input | 1 | Register read strobe; a read of a clear address clears at the end of the cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Word address of the register accessed |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid in the cycle `regRdEn` is high |
| srcIn | input | 12 | Event pulses (bits 2..11) and level conditions (bits 0..1) |
| abortReasonIn | input | ABORT_W | Abort reason bits, sampled with a transmit-abort pulse |
| ctrlEnable | input | 1 | Controller enabled; qualifies activity as an interrupt |
| irqOut | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its defaults: 32-bit data, 5-bit addresses and an 8-bit abort-reason register. With these values all twelve sources, all twelve clear addresses and the combined clear fit in a small address space and can each be swept in turn. Every event source is set, held, cleared by its own address and by the combined clear, and hit with a coincident pulse during a clear. The mask is swept over every single-bit value and over a family of arithmetic raw and mask patterns, with the expected masked status and line level computed in the bench. Abort-reason accumulation, coincident capture and clearing are exercised together with the activity gating under both controller-enable states.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int NUM_SRC = 12;

  // source bit positions
  localparam int SRC_TXLOW    = 0;   // level: transmit below threshold
  localparam int SRC_RXHIGH   = 1;   // level: receive at threshold
  localparam int SRC_TXABORT  = 2;
  localparam int SRC_STOPSEEN = 3;
  localparam int SRC_STRTSEEN = 4;
  localparam int SRC_ACTIVE   = 5;
  localparam int SRC_RXUNDER  = 6;
  localparam int SRC_RXOVER   = 7;
  localparam int SRC_TXOVER   = 8;
  localparam int SRC_RDREQ    = 9;
  localparam int SRC_RXDONE   = 10;
  localparam int SRC_GENCALL  = 11;

  localparam logic [NUM_SRC-1:0] LEVEL_SRC = {{(NUM_SRC-2){1'b0}}, 2'b11};
  localparam logic [NUM_SRC-1:0] CLEARABLE = ~LEVEL_SRC;

  // register word addresses
  localparam int ADDR_RAW     = 0;
  localparam int ADDR_MASKED  = 1;
  localparam int ADDR_MASK    = 2;
  localparam int ADDR_ABORT   = 3;
  localparam int ADDR_CLRALL  = 4;
  localparam int ADDR_CLRBASE = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RAW, SEL_MASKED, SEL_MASK, SEL_ABORT, SEL_CLRALL, SEL_CLRONE
  } rdSel_e;

  typedef struct packed {
    logic               clrAll;
    logic [NUM_SRC-1:0] clrOne;
    logic               maskWr;
    rdSel_e             rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  logic [NUM_SRC-1:0] clrHit;

  // one decoder per source clear address
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clrdec
    localparam int CLR_ADDR = ADDR_CLRBASE + i;
    assign clrHit[i] = (regAddr == ADDR_W'(CLR_ADDR));
  end

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    strobe.maskWr = regWrEn && (regAddr == ADDR_W'(ADDR_MASK));
    if (regRdEn) begin
      if (regAddr == ADDR_W'(ADDR_RAW)) begin
        strobe.rdSel = SEL_RAW;
      end else if (regAddr == ADDR_W'(ADDR_MASKED)) begin
        strobe.rdSel = SEL_MASKED;
      end else if (regAddr == ADDR_W'(ADDR_MASK)) begin
        strobe.rdSel = SEL_MASK;
      end else if (regAddr == ADDR_W'(ADDR_ABORT)) begin
        strobe.rdSel = SEL_ABORT;
      end else if (regAddr == ADDR_W'(ADDR_CLRALL)) begin
        strobe.rdSel = SEL_CLRALL;
        strobe.clrAll = 1'b1;
      end else if (|clrHit) begin
        strobe.rdSel = SEL_CLRONE;
        strobe.clrOne = clrHit & CLEARABLE;
      end
    end
  end
endmodule

// File: rtl/irqbank_datapath.sv
module irqbank_datapath
  import irqbank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ABORT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ABORT_W-1:0] abortReasonIn,
  input  logic               ctrlEnable,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  localparam logic [NUM_SRC-1:0] ACT_BIT = NUM_SRC'(1) << SRC_ACTIVE;

  logic [NUM_SRC-1:0] rawEv, rawStat, maskQ, maskedStat, clrEff, evtPulse;
  logic [ABORT_W-1:0] abortQ;
  logic               irqQ, irqNext, abortPulse, abortClr;
  logic [DATA_W-1:0]  unusedWrBits;

  assign unusedWrBits = wrData & ~DATA_W'({NUM_SRC{1'b1}});

  assign evtPulse = srcIn & CLEARABLE;
  assign clrEff   = strobe.clrAll ? CLEARABLE : (strobe.clrOne & CLEARABLE);

  // event latches: a pulse in the clearing cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawEv <= '0;
    else       rawEv <= evtPulse | (rawEv & ~clrEff);
  end

  assign rawStat    = (rawEv & CLEARABLE) | (srcIn & LEVEL_SRC);
  assign maskedStat = rawStat & maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wrData[NUM_SRC-1:0];
  end

  // abort reason accumulates while the abort bit is pending
  assign abortPulse = srcIn[SRC_TXABORT];
  assign abortClr   = clrEff[SRC_TXABORT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           abortQ <= '0;
    else if (abortPulse) abortQ <= (abortClr ? '0 : abortQ) | abortReasonIn;
    else if (abortClr)   abortQ <= '0;
  end

  // activity alone only counts while the controller is enabled
  assign irqNext = ctrlEnable ? (|maskedStat) : (|(maskedStat & ~ACT_BIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= irqNext;
  end
  assign irqOut = irqQ;

  always_comb begin
    case (strobe.rdSel)
      SEL_RAW:    rdData = DATA_W'(rawStat);
      SEL_MASKED: rdData = DATA_W'(maskedStat);
      SEL_MASK:   rdData = DATA_W'(maskQ);
      SEL_ABORT:  rdData = DATA_W'(abortQ);
      SEL_CLRALL: rdData = DATA_W'(rawStat);
      SEL_CLRONE: rdData = DATA_W'(|(rawStat & strobe.clrOne));
      default:    rdData = '0;
    endcase
  end

  // R1: an uncleared event bit stays set
  a_r1_event_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((rawEv & ~clrEff) != '0) |=>
      ((rawEv & $past(rawEv & ~clrEff)) == $past(rawEv & ~clrEff)));

  // R2: a pulse is latched even during a clear
  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((rawEv & $past(evtPulse)) == $past(evtPulse)));

  // R4: combined clear with no new pulse empties the event bits
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrAll && evtPulse == '0) |=> (rawEv == '0));

  // R7: zero mask keeps the line low
  a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> !irqOut);

  // R10: abort clear without a new abort empties the reason
  a_r10_abort_clear: assert property (@(posedge clk) disable iff (!rstN)
    (abortClr && !abortPulse) |=> (abortQ == '0));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irqbank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int ABORT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regRdEn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ABORT_W-1:0] abortReasonIn,
  input  logic               ctrlEnable,
  output logic               irqOut
);
  ctrlStrobe_t strobe;

  irqbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regRdEn (regRdEn),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irqbank_datapath #(.DATA_W(DATA_W), .ABORT_W(ABORT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (regWrData),
    .srcIn         (srcIn),
    .abortReasonIn (abortReasonIn),
    .ctrlEnable    (ctrlEnable),
    .rdData        (regRdData),
    .irqOut        (irqOut)
  );
endmodule

// File: tb/irq_status_bank_test.sv
module irq_status_bank_test;
  localparam logic [4:0] A_RAW = 5'd0, A_MASKED = 5'd1, A_MASK = 5'd2,
                         A_ABORT = 5'd3, A_CLRALL = 5'd4, A_CLRBASE = 5'd8;
  localparam logic [11:0] EV_ALL = 12'hFFC;
  localparam int B_ABORT = 2, B_ACTIVE = 5, B_STOP = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0, ctrlEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [11:0] evt = '0;
  logic [1:0]  lvl = '0;
  logic [7:0]  abortIn = '0;
  logic        irq;
  int          nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  irq_status_bank uut (
    .clk(clk), .rstN(rstN), .regRdEn(rdEn), .regWrEn(wrEn), .regAddr(addr),
    .regWrData(wrData), .regRdData(rdData), .srcIn(evt | {10'b0, lvl}),
    .abortReasonIn(abortIn), .ctrlEnable(ctrlEn), .irqOut(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [11:0] v, input logic [7:0] why);
    @(negedge clk); evt = v; abortIn = why;
    @(negedge clk); evt = '0; abortIn = '0;
  endtask

  task automatic readPulse(input logic [4:0] a, input logic [11:0] v,
                           input logic [7:0] why, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; evt = v; abortIn = why;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0; evt = '0; abortIn = '0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    readPulse(a, '0, '0, d);
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wrData = v; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    regRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic expectIrq(input string tag, input logic exp);
    repeat (2) @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state and mask access
    check("R12 irq after reset", {31'b0, irq}, 32'd0);
    expectReg("R12 raw after reset", A_RAW, 32'h0);
    expectReg("R12 mask after reset", A_MASK, 32'h0);
    expectReg("R12 abort after reset", A_ABORT, 32'h0);
    regWrite(A_MASK, 32'h0000_0ABC);
    expectReg("R12 mask readback", A_MASK, 32'h0000_0ABC);
    regWrite(A_MASK, 32'hFFFF_FFFF);
    expectReg("R12 mask keeps 12 bits", A_MASK, 32'h0000_0FFF);
    regWrite(A_MASK, 32'h0);

    // R1 R3 R4 R11: each event source set, held and cleared
    for (int i = 2; i < 12; i++) begin
      logic [11:0] b;
      b = 12'(1) << i;
      pulse(b, 8'h00);
      repeat (4) @(negedge clk);
      expectReg($sformatf("R1 hold src %0d", i), A_RAW, {20'b0, b});
      pulse(EV_ALL, 8'h00);
      expectReg($sformatf("R11 clear read src %0d", i), A_CLRBASE + 5'(i), 32'h1);
      expectReg($sformatf("R3 only src %0d cleared", i), A_RAW, {20'b0, EV_ALL & ~b});
      expectReg($sformatf("R4 clear-all returns src %0d", i), A_CLRALL, {20'b0, EV_ALL & ~b});
      expectReg($sformatf("R4 empty after clear-all %0d", i), A_RAW, 32'h0);
    end

    // R2: coincident pulse beats the clear
    for (int i = 2; i < 12; i++) begin
      logic [11:0] b;
      b = 12'(1) << i;
      pulse(EV_ALL, 8'h00);
      readPulse(A_CLRBASE + 5'(i), b, 8'h00, d);
      check($sformatf("R11 clear read with pulse %0d", i), d, 32'h1);
      expectReg($sformatf("R2 per-source set wins %0d", i), A_RAW, {20'b0, EV_ALL});
      readPulse(A_CLRALL, b, 8'h00, d);
      expectReg($sformatf("R2 clear-all set wins %0d", i), A_RAW, {20'b0, b});
      regRead(A_CLRALL, d);
    end

    // R5: level sources
    lvl = 2'b01;
    expectReg("R5 level 0 visible", A_RAW, 32'h1);
    expectReg("R5 level 0 clear reads 0", A_CLRBASE, 32'h0);
    expectReg("R5 level 0 not cleared", A_RAW, 32'h1);
    expectReg("R5 clear-all returns level", A_CLRALL, 32'h1);
    expectReg("R5 level survives clear-all", A_RAW, 32'h1);
    lvl = 2'b10;
    expectReg("R5 level 1 follows", A_RAW, 32'h2);
    expectReg("R5 level 1 clear reads 0", A_CLRBASE + 5'd1, 32'h0);
    lvl = 2'b00;
    expectReg("R5 level drops", A_RAW, 32'h0);

    // R6 R7: single-bit mask sweep
    ctrlEn = 1'b1;
    lvl = 2'b11;
    pulse(EV_ALL, 8'h00);
    for (int k = 0; k < 12; k++) begin
      regWrite(A_MASK, 32'(1) << k);
      expectReg($sformatf("R6 masked single %0d", k), A_MASKED, 32'(1) << k);
      expectIrq($sformatf("R7 irq single %0d", k), 1'b1);
    end
    regWrite(A_MASK, 32'h0);
    expectReg("R6 masked with zero mask", A_MASKED, 32'h0);
    expectIrq("R7 zero mask silences", 1'b0);
    regRead(A_CLRALL, d);
    regWrite(A_MASK, 32'h0000_0FFC);
    expectIrq("R7 levels masked off", 1'b0);
    regWrite(A_MASK, 32'h0000_0FFF);
    expectIrq("R7 level source raises", 1'b1);
    lvl = 2'b00;

    // R6 R7: arithmetic raw and mask patterns
    for (int j = 0; j < 16; j++) begin
      logic [11:0] rp, mp, ex;
      rp = 12'(j * 12'h137) & EV_ALL;
      mp = 12'(j * 12'h2D9);
      regRead(A_CLRALL, d);
      if (rp != '0) pulse(rp, 8'h00);
      regWrite(A_MASK, {20'b0, mp});
      ex = rp & mp;
      expectReg($sformatf("R6 pattern %0d", j), A_MASKED, {20'b0, ex});
      expectIrq($sformatf("R7 pattern %0d", j), |ex);
    end

    // R8: activity gating
    regRead(A_CLRALL, d);
    regWrite(A_MASK, 32'h0000_0FFF);
    ctrlEn = 1'b0;
    pulse(12'(1) << B_ACTIVE, 8'h00);
    expectIrq("R8 activity alone while disabled", 1'b0);
    expectReg("R8 activity still in masked", A_MASKED, 32'(1) << B_ACTIVE);
    ctrlEn = 1'b1;
    expectIrq("R8 activity while enabled", 1'b1);
    ctrlEn = 1'b0;
    pulse(12'(1) << B_STOP, 8'h00);
    expectIrq("R8 other source while disabled", 1'b1);
    regRead(A_CLRALL, d);
    ctrlEn = 1'b1;

    // R9 R10: abort reason
    pulse(12'(1) << B_ABORT, 8'h05);
    expectReg("R9 first reason", A_ABORT, 32'h05);
    @(negedge clk); abortIn = 8'hFF;
    repeat (2) @(negedge clk); abortIn = 8'h00;
    expectReg("R9 reason without pulse ignored", A_ABORT, 32'h05);
    pulse(12'(1) << B_ABORT, 8'h30);
    expectReg("R9 reasons accumulate", A_ABORT, 32'h35);
    expectReg("R9 reason read has no side effect", A_ABORT, 32'h35);
    expectReg("R10 other clear keeps reason", A_CLRBASE + 5'd3, 32'h0);
    expectReg("R10 reason kept", A_ABORT, 32'h35);
    expectReg("R10 abort clear read", A_CLRBASE + 5'(B_ABORT), 32'h1);
    expectReg("R10 reason emptied", A_ABORT, 32'h0);
    expectReg("R10 abort bit cleared", A_RAW, 32'h0);
    pulse(12'(1) << B_ABORT, 8'h0A);
    regRead(A_CLRALL, d);
    expectReg("R10 clear-all empties reason", A_ABORT, 32'h0);
    pulse(12'(1) << B_ABORT, 8'h01);
    readPulse(A_CLRBASE + 5'(B_ABORT), 12'(1) << B_ABORT, 8'h40, d);
    expectReg("R10 coincident abort keeps new reason", A_ABORT, 32'h40);
    regRead(A_CLRALL, d);

    // R11: writes elsewhere and unused reads
    pulse(EV_ALL, 8'h00);
    regWrite(A_RAW, 32'h0);
    regWrite(A_CLRALL, 32'h0);
    regWrite(A_CLRBASE + 5'd3, 32'h0);
    expectReg("R11 writes ignored", A_RAW, {20'b0, EV_ALL});
    expectReg("R11 unused address reads 0", 5'd5, 32'h0);
    expectReg("R11 unused read harmless", A_RAW, {20'b0, EV_ALL});

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule